// File: doc/BRIEF.md
# SPI Banked Register Engine

This block is an SPI slave that runs a small command set against a banked space of eight-bit control registers. It works in SPI mode 0 and shifts the most significant bit first. Each command starts when chip select falls and ends when it rises. The first byte is the command. Its top three bits select the operation and its low five bits give a register address. The data bytes follow the command.

The register space has four banks of 32 addresses. Addresses 0x00 to 0x1A are separate in each bank. Addresses 0x1B to 0x1F are shared by all four banks, and address 0x1F holds the bank-select bits. A small internal byte buffer can be streamed in either direction through an auto-incrementing pointer. That pointer can also be read and written as a register pair in bank 0.

The SPI pins are sampled with the system clock. Each SCLK half period must last at least six system clock cycles.

Top module: `spi_bank_regs`

## Requirements
- R1: The command byte is decoded as operation = bits 7:5 and address = bits 4:0. The operation codes are 000 register read, 010 register write, 100 bit set, 101 bit clear, 001 buffer read, 011 buffer write, 111 soft reset and 110 unused. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge.
- R2: A register write is the command 0x40|addr followed by one data byte. It stores that byte once the data byte is complete.
- R3: The selected bank is bit1×2 + bit0 of register 0x1F. Addresses 0x00–0x1A are separate per bank, and 0x1B–0x1F are the same registers in every bank.
- R4: Bit set (0x80|addr, data) ORs the data into the register. Bit clear (0xA0|addr, data) ANDs the register with the inverted data. Both also act on 0x1F and so change the bank.
- R5: For an ordinary register read, MISO returns 0x00 during the command byte and the register value in the byte immediately after it. Every later byte of that transaction returns 0x00.
- R6: Reads from the slow group return one 0x00 dummy byte and then the value. The slow group is bank 2 addresses 0x00–0x1A and bank 3 addresses 0x00–0x05 and 0x0A.
- R7: The single byte 0xFF clears every register, the bank bits and the buffer pointer. Buffer contents are kept.
- R8: After the header 0x7A, each following byte is stored at the pointer. The pointer then advances and wraps at BUF_DEPTH (16).
- R9: After the header 0x3A, each following byte returns the buffer entry at the pointer. The pointer advances after each completed byte.
- R10: In bank 0, address 0x00 reads the pointer's low byte and 0x01 reads its high byte, which is 0 for a depth of 16. A write or bit operation on either address loads the resulting 16-bit value modulo BUF_DEPTH.
- R11: While chip select is high, spi_miso_oe and spi_miso are both 0.
- R12: If chip select rises before a byte has all 8 bits, that byte is dropped and no register or buffer entry changes.
- R13: Opcode 110 is ignored, as are 001, 011 and 111 with any byte other than 0x3A, 0x7A and 0xFF. Such a command changes nothing, and MISO returns 0x00 for the rest of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select that frames a command |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave, 0 when deselected |
| spi_miso_oe | output | 1 | High while MISO is actively driven |

## Verification
A register change or pointer step happens a few system clocks after the rising SCLK edge that completes the byte: two synchronizer stages, an edge register, then the update. Read data appears on MISO from the falling edge that follows the completing byte. The bench therefore samples MISO only at its own rising SCLK edges, and each half period is six system clocks, so every register on that path has settled before the sample. Register and pointer contents are checked only through later read commands, after chip select has gone high and low again.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

  localparam logic [4:0] SHARED_FROM = 5'h1B;
  localparam logic [7:0] HDR_RDBUF   = 8'h3A;
  localparam logic [7:0] HDR_WRBUF   = 8'h7A;
  localparam logic [7:0] HDR_RESET   = 8'hFF;

  typedef enum logic [2:0] {
    OP_RDREG = 3'b000,
    OP_RDBUF = 3'b001,
    OP_WRREG = 3'b010,
    OP_WRBUF = 3'b011,
    OP_SETB  = 3'b100,
    OP_CLRB  = 3'b101,
    OP_NONE  = 3'b110,
    OP_RESET = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    S_CMD, S_DUMMY, S_WDATA, S_BRD, S_BWR, S_MUTE
  } st_e;

  function automatic op_e op_of(input logic [7:0] b);
    return op_e'(b[7:5]);
  endfunction

  function automatic logic [4:0] addr_of(input logic [7:0] b);
    return b[4:0];
  endfunction

  // slow group needs one dummy byte ahead of the read data
  function automatic logic slow_read(input logic [1:0] bank, input logic [4:0] a);
    case (bank)
      2'd2:    return a < SHARED_FROM;
      2'd3:    return (a <= 5'h05) || (a == 5'h0A);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] apply_op(input op_e op, input logic [7:0] cur,
                                          input logic [7:0] d);
    case (op)
      OP_SETB: return cur | d;
      OP_CLRB: return cur & ~d;
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       active,
  output logic       miso_bit
);
  logic [SYNC-1:0] sclk_s, cs_s, mosi_s;
  logic            sclk_d;
  logic [2:0]      bit_cnt;
  logic [6:0]      rx_sr;
  logic [7:0]      tx_sr;
  logic            rise, fall;

  assign active   = ~cs_s[SYNC-1];
  assign rise     = sclk_s[SYNC-1] & ~sclk_d;
  assign fall     = ~sclk_s[SYNC-1] & sclk_d;
  assign miso_bit = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s    <= '0;
      cs_s      <= '1;
      mosi_s    <= '0;
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      sclk_s    <= {sclk_s[SYNC-2:0], sclk};
      cs_s      <= {cs_s[SYNC-2:0], cs_n};
      mosi_s    <= {mosi_s[SYNC-2:0], mosi};
      sclk_d    <= sclk_s[SYNC-1];
      byte_done <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_s[SYNC-1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sr, mosi_s[SYNC-1]};
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) tx_sr <= tx_byte;
          else                 tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  // R12: a new frame always starts counting from bit zero
  a_r12_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> bit_cnt == 3'd0);

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int NB = 4,
  parameter int AW = 5,
  parameter int SHARED_FROM = 27,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [BW-1:0] bank
);
  localparam int NREG      = 2 ** AW;
  localparam int DEPTH     = NB * SHARED_FROM + (NREG - SHARED_FROM);
  localparam int IW        = $clog2(DEPTH);
  localparam int BANK_SLOT = NB * SHARED_FROM + (NREG - 1 - SHARED_FROM);

  logic [7:0] mem [DEPTH];

  function automatic logic [IW-1:0] slot(input logic [BW-1:0] b, input logic [AW-1:0] a);
    if (int'(a) >= SHARED_FROM) return IW'(NB * SHARED_FROM + int'(a) - SHARED_FROM);
    return IW'(int'(b) * SHARED_FROM + int'(a));
  endfunction

  assign bank    = mem[BANK_SLOT][BW-1:0];
  assign rd_data = mem[slot(bank, rd_addr)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[slot(bank, wr_addr)] <= wr_data;
    end
  end

  // R3: a write to the top address moves the bank on the next cycle
  a_r3_bank_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && wr_addr == AW'(NREG - 1)) |=> bank == $past(wr_data[BW-1:0]));

  // R7: soft reset returns to bank 0
  a_r7_clear_bank: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> bank == '0);

endmodule

// File: rtl/byte_buffer.sv
module byte_buffer #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_val,
  input  logic          step,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic [PW-1:0] ptr
);
  logic [7:0] mem [DEPTH];

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign rd_data = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (clear)    ptr <= '0;
    else if (ptr_load) ptr <= ptr_val;
    else if (step)     ptr <= next_ptr(ptr);
  end

  // R8: each buffered byte advances the pointer by one, wrapping at the end
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !ptr_load) |=>
      ptr == (($past(ptr) == PW'(DEPTH - 1)) ? '0 : $past(ptr) + PW'(1)));

endmodule

// File: rtl/spi_bank_regs.sv
module spi_bank_regs
  import spi_bank_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int NB = 4;
  localparam int AW = 5;
  localparam int PW = $clog2(BUF_DEPTH);

  logic       byte_done, active, miso_bit;
  logic [7:0] rx_byte, tx_byte, out_byte;
  st_e        st;
  op_e        lat_op;
  logic [4:0] lat_addr, rd_addr;
  logic [7:0] reg_rd, cur_val, new_val, buf_rd;
  logic [1:0] bank;
  logic [PW-1:0] ptr, ptr_new;
  logic [15:0] ptr16, ptr_cand;
  logic       reg_wr_en, ptr_hit, do_reset, buf_wr, buf_step, rd_cmd;

  spi_byte_link #(.SYNC(SYNC)) u_link (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .active(active), .miso_bit(miso_bit));

  bank_regfile #(.NB(NB), .AW(AW), .SHARED_FROM(int'(SHARED_FROM))) u_regs (
    .clk(clk), .rst_n(rst_n), .clear(do_reset), .wr_en(reg_wr_en),
    .wr_addr(lat_addr), .wr_data(new_val), .rd_addr(rd_addr),
    .rd_data(reg_rd), .bank(bank));

  byte_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(do_reset), .ptr_load(ptr_hit),
    .ptr_val(ptr_new), .step(buf_step), .wr_en(buf_wr), .wr_data(rx_byte),
    .rd_data(buf_rd), .ptr(ptr));

  // register view: bank 0 addresses 0 and 1 show the buffer pointer
  assign rd_addr = (st == S_CMD) ? addr_of(rx_byte) : lat_addr;
  assign ptr16   = 16'(ptr);
  always_comb begin
    cur_val = reg_rd;
    if (bank == 2'd0 && rd_addr <= 5'd1)
      cur_val = rd_addr[0] ? ptr16[15:8] : ptr16[7:0];
  end

  // commit events
  assign new_val   = apply_op(lat_op, cur_val, rx_byte);
  assign reg_wr_en = byte_done && st == S_WDATA;
  assign ptr_hit   = reg_wr_en && bank == 2'd0 && lat_addr <= 5'd1;
  assign ptr_cand  = lat_addr[0] ? {new_val, ptr16[7:0]} : {ptr16[15:8], new_val};
  assign ptr_new   = PW'(ptr_cand % 16'(BUF_DEPTH));
  assign do_reset  = byte_done && st == S_CMD && rx_byte == HDR_RESET;
  assign buf_wr    = byte_done && st == S_BWR;
  assign buf_step  = buf_wr || (byte_done && st == S_BRD);
  assign rd_cmd    = byte_done && st == S_CMD && op_of(rx_byte) == OP_RDREG &&
                     !slow_read(bank, addr_of(rx_byte));

  assign tx_byte     = (st == S_BRD) ? buf_rd : out_byte;
  assign spi_miso_oe = ~spi_cs_n;
  assign spi_miso    = spi_miso_oe & miso_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CMD;
      out_byte <= '0;
      lat_op   <= OP_NONE;
      lat_addr <= '0;
    end else if (!active) begin
      st       <= S_CMD;
      out_byte <= '0;
    end else if (byte_done) begin
      out_byte <= '0;
      case (st)
        S_CMD: begin
          lat_op   <= op_of(rx_byte);
          lat_addr <= addr_of(rx_byte);
          case (op_of(rx_byte))
            OP_RDREG: begin
              if (slow_read(bank, addr_of(rx_byte))) st <= S_DUMMY;
              else begin
                out_byte <= cur_val;
                st       <= S_MUTE;
              end
            end
            OP_WRREG, OP_SETB, OP_CLRB: st <= S_WDATA;
            OP_RDBUF: st <= (rx_byte == HDR_RDBUF) ? S_BRD : S_MUTE;
            OP_WRBUF: st <= (rx_byte == HDR_WRBUF) ? S_BWR : S_MUTE;
            default:  st <= S_MUTE;
          endcase
        end
        S_DUMMY: begin
          out_byte <= cur_val;
          st       <= S_MUTE;
        end
        S_WDATA: st <= S_MUTE;
        S_BRD, S_BWR: st <= st;
        default: st <= S_MUTE;
      endcase
    end
  end

  // R11: nothing is written while deselected
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(reg_wr_en || buf_wr || do_reset));

  // R5: a plain read queues the value and silences the rest of the frame
  a_r5_direct_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> (!active || (st == S_MUTE && out_byte == $past(cur_val))));

endmodule

// File: tb/spi_bank_regs_test.sv
module spi_bank_regs_test;
  localparam int HALF = 6;
  localparam int DEP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_regs [4][32];
  logic [7:0] m_buf [DEP];
  int m_ptr = 0;

  always #4 clk = ~clk;

  spi_bank_regs uut (.clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // ---- model from the requirements ----
  function automatic int mbank();
    return int'(m_regs[0][31][1:0]);
  endfunction
  function automatic int home(input int b, input int a);
    return (a >= 27) ? 0 : b;
  endfunction
  function automatic logic [7:0] mread(input int a);
    if (mbank() == 0 && a == 0) return 8'(m_ptr);
    if (mbank() == 0 && a == 1) return 8'h00;
    return m_regs[home(mbank(), a)][a];
  endfunction
  function automatic void mwrite(input int a, input logic [7:0] v);
    if (mbank() == 0 && a <= 1) begin
      if (a == 0) m_ptr = int'(v) % DEP;
    end else m_regs[home(mbank(), a)][a] = v;
  endfunction
  function automatic bit mslow(input int b, input int a);
    if (b == 2) return a <= 26;
    if (b == 3) return a <= 5 || a == 10;
    return 0;
  endfunction
  function automatic void mclear();
    for (int b = 0; b < 4; b++) for (int a = 0; a < 32; a++) m_regs[b][a] = 8'h00;
    m_ptr = 0;
  endfunction

  // ---- SPI master ----
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      rx[i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask
  task automatic cs_lo();
    @(negedge clk); spi_cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask
  task automatic cs_hi();
    repeat (HALF) @(negedge clk); spi_cs_n = 1'b1; repeat (HALF) @(negedge clk);
  endtask

  task automatic op_write(input logic [2:0] op, input int a, input logic [7:0] d);
    logic [7:0] rx, cur;
    cs_lo(); xfer({op, 5'(a)}, rx); xfer(d, rx); cs_hi();
    cur = mread(a);
    case (op)
      3'b100:  mwrite(a, cur | d);
      3'b101:  mwrite(a, cur & ~d);
      default: mwrite(a, d);
    endcase
  endtask

  task automatic op_read(input string tag, input int a);
    logic [7:0] rx;
    cs_lo();
    xfer({3'b000, 5'(a)}, rx); check({tag, " R5 cmd byte"}, rx, 8'h00);
    if (mslow(mbank(), a)) begin
      xfer(8'h00, rx); check({tag, " R6 dummy"}, rx, 8'h00);
    end
    xfer(8'h00, rx); check({tag, " data"}, rx, mread(a));
    xfer(8'h00, rx); check({tag, " R5 trailing"}, rx, 8'h00);
    cs_hi();
  endtask

  task automatic buf_write(input int n);
    logic [7:0] rx, d;
    cs_lo(); xfer(8'h7A, rx);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      xfer(d, rx);
      m_buf[m_ptr] = d; m_ptr = (m_ptr + 1) % DEP;
    end
    cs_hi();
  endtask

  task automatic buf_read(input int n);
    logic [7:0] rx;
    cs_lo(); xfer(8'h3A, rx);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, rx); check("R9 buffer read", rx, m_buf[m_ptr]);
      m_ptr = (m_ptr + 1) % DEP;
    end
    cs_hi();
  endtask

  task automatic soft_reset();
    logic [7:0] rx;
    cs_lo(); xfer(8'hFF, rx); cs_hi();
    mclear();
  endtask

  task automatic ignored(input logic [7:0] cmd);
    logic [7:0] rx;
    cs_lo(); xfer(cmd, rx);
    for (int i = 0; i < 2; i++) begin
      xfer(8'($urandom), rx); check("R13 ignored command output", rx, 8'h00);
    end
    cs_hi();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5EED_1234));
    mclear();
    for (int i = 0; i < DEP; i++) m_buf[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset and idle state
    check("R11 oe idle", {7'd0, spi_miso_oe}, 8'h00);
    check("R11 miso idle", {7'd0, spi_miso}, 8'h00);
    op_read("R7 reset bank reg", 31);

    // R1 R2 plain write and read
    op_write(3'b010, 5, 8'hA5);
    op_read("R1 R2 write readback", 5);
    op_write(3'b010, 27, 8'h3C);
    // R3 bank switch and shared addresses
    op_write(3'b010, 31, 8'h02);
    op_read("R3 R6 bank2 slow", 5);
    op_write(3'b010, 5, 8'h77);
    op_read("R3 bank2 write", 5);
    op_read("R3 shared in bank2", 27);
    op_write(3'b010, 28, 8'h91);
    // R4 bit ops on bank select
    op_write(3'b101, 31, 8'h02);
    op_write(3'b100, 31, 8'h01);
    op_read("R4 R3 bank1 shared", 28);
    op_write(3'b100, 31, 8'h02);
    op_read("R6 bank3 slow", 10);
    op_read("R6 bank3 plain", 7);
    op_write(3'b101, 31, 8'h03);
    op_read("R3 bank0 kept", 5);
    op_write(3'b100, 5, 8'h0A);
    op_read("R4 set", 5);
    op_write(3'b101, 5, 8'h21);
    op_read("R4 clear", 5);

    // R10 pointer register, R8/R9 buffer with wrap
    op_write(3'b010, 0, 8'h1E);
    op_read("R10 pointer low", 0);
    op_read("R10 pointer high", 1);
    buf_write(4);
    op_read("R8 pointer after wrap", 0);
    op_write(3'b010, 0, 8'h0E);
    buf_read(4);
    op_read("R9 pointer after read", 0);

    // R12 partial byte is dropped
    cs_lo(); xfer(8'h45, rx);
    for (int i = 7; i >= 3; i--) begin
      spi_mosi = 1'b1; repeat (HALF) @(negedge clk); spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk); spi_sclk = 1'b0;
    end
    cs_hi();
    op_read("R12 partial dropped", 5);

    // R13 ignored commands leave state intact
    ignored(8'hC5);
    ignored(8'h3B);
    ignored(8'hE0);
    op_read("R13 state kept", 5);

    // R7 soft reset keeps buffer contents
    op_write(3'b010, 31, 8'h01);
    soft_reset();
    op_read("R7 bank cleared", 31);
    op_read("R7 reg cleared", 5);
    op_read("R7 pointer cleared", 0);
    m_ptr = 14;
    op_write(3'b010, 0, 8'h0E);
    buf_read(2);

    // random mix
    for (int it = 0; it < 140; it++) begin
      int k, a;
      k = int'($urandom % 10);
      a = int'($urandom % 32);
      case (k)
        0, 1:    op_write(3'b010, a, 8'($urandom));
        2:       op_write(3'b100, a, 8'($urandom));
        3:       op_write(3'b101, a, 8'($urandom));
        4, 5, 6: op_read("R2 random read", a);
        7:       buf_write(1 + int'($urandom % 5));
        8:       buf_read(1 + int'($urandom % 5));
        default: if (($urandom % 4) == 0) soft_reset();
                 else ignored({3'b110, 5'(a)});
      endcase
    end
    check("R11 oe after run", {7'd0, spi_miso_oe}, 8'h00);
    finish_run();
  end
endmodule